// File: doc/BRIEF.md
# Host-Mapped UART Byte Queues

This block sits between a host bus and a UART. It holds a transmit queue and a receive queue of bytes. The host sees a small register window: a status word, a count of free transmit slots, a count of received bytes waiting, a one-byte data port, and a 1 KiB window for burst transfers in which a 16-bit access moves two bytes. On the line side, queued transmit bytes go to a serializer through a valid/ready handshake, and received bytes come in from a deserializer as single-cycle strobes. The serializer and deserializer are not part of this block.

Transmission can be gated by the peer's clear-to-send line when flow control is enabled. A small state machine paces the transmit side. It has three states. In `TXS_IDLE` the queue is empty. In `TXS_OFFER` the head byte is presented with `tx_valid`. In `TXS_HOLD` bytes are queued but the peer is not ready. Its transitions are:
- *fill*: IDLE→OFFER, or IDLE→HOLD when blocked.
- *block*: OFFER→HOLD.
- *release*: HOLD→OFFER.
- *drain*: OFFER→IDLE when the last byte is taken.

The next state is computed from the queue's count after the current cycle's push and pop, and from the current flow-control condition.

A receive byte that arrives while the receive queue is full is lost. This loss is latched in a sticky overflow flag that the host clears by writing a one to it.

Top module: `uart_fifo_port`

## Requirements
- R1: After reset, both queues are empty, `tx_valid` is 0, the status word reads 0x001, the free count reads DEPTH, and the ready count reads 0.
- R2: The status word at offset 0x14 carries transmit flags in bits 3:0 and receive flags in bits 11:8. The transmit flags are: bit 0 not full, bit 1 full, bit 2 half full, bit 3 active. The receive flags are: bit 8 not empty, bit 9 full, bit 10 half full, bit 11 overflow. All other bits read 0.
- R3: Offset 0x18 returns DEPTH minus the transmit occupancy, zero-extended, in bits 10:0.
- R4: Offset 0x1C returns the receive occupancy, zero-extended, in bits 10:0.
- R5: A write to offset 0x20 queues `bus_wdata[7:0]` for transmission. A read of offset 0x20 returns the oldest received byte in bits 7:0 and removes it. A read with the receive queue empty returns 0 and changes nothing.
- R6: In the window 0x1000–0x13FF, a narrow access (`bus_wide`=0) moves one byte in bits 7:0. A wide write queues `bus_wdata[15:8]` first and then `bus_wdata[7:0]`. A wide read returns the older byte in bits 15:8 and the next byte in bits 7:0, and removes both. A byte position with no byte behind it reads 0.
- R7: A write when the transmit queue is full is ignored. A wide write with only one free slot queues only the high byte.
- R8: A receive strobe while the receive queue is full drops the byte and sets the overflow flag. The flag stays set until a status write with bit 11 = 1. A status write with bit 11 = 0 leaves it set. A new overflow in the same cycle as a clear leaves it set.
- R9: `tx_valid` rises in the cycle after the write that fills an empty queue, with `tx_data` equal to the head byte. A byte is removed on `tx_valid && tx_ready`. Bytes leave in the order they were queued.
- R10: With `fc_en`=1 and `peer_cts`=0, `tx_valid` is 0 from the next cycle on. With `fc_en`=0, `peer_cts` has no effect.
- R11: Status bit 3 is 1 whenever `tx_busy` is 1 or the transmit queue holds at least one byte.
- R12: A half-full flag is 1 exactly when its queue holds at least DEPTH/2 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Host access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 16-bit access (window only) |
| bus_addr | input | 13 | Byte offset within the block |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational |
| fc_en | input | 1 | Enable clear-to-send gating |
| peer_cts | input | 1 | Peer ready to receive |
| tx_busy | input | 1 | Serializer is shifting a byte |
| tx_valid | output | 1 | Byte offered to serializer |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_data | output | 8 | Byte offered to serializer |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |

## Verification
The bench builds the block with `DEPTH_LOG2` = 3, which gives eight-entry queues. With this depth, the full, half-full, one-free-slot and overflow boundaries are reached within a few dozen host accesses. These cases are expensive to reach at the default depth of 1024. The reduced depth also lets every byte's order be checked individually. The bench also tests the case where a new overflow and the host's clear land in the same cycle.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int unsigned ADDR_W = 13;

    localparam logic [ADDR_W-1:0] OFS_STATUS  = 13'h014;
    localparam logic [ADDR_W-1:0] OFS_TXFREE  = 13'h018;
    localparam logic [ADDR_W-1:0] OFS_RXREADY = 13'h01C;
    localparam logic [ADDR_W-1:0] OFS_DATA    = 13'h020;
    localparam logic [2:0]        WIN_TOP     = 3'b100;

    localparam int unsigned ST_TX_NF  = 0;
    localparam int unsigned ST_TX_F   = 1;
    localparam int unsigned ST_TX_HF  = 2;
    localparam int unsigned ST_TX_ACT = 3;
    localparam int unsigned ST_RX_NE  = 8;
    localparam int unsigned ST_RX_F   = 9;
    localparam int unsigned ST_RX_HF  = 10;
    localparam int unsigned ST_RX_OVF = 11;

    typedef enum logic [1:0] {
        TXS_IDLE  = 2'd0,
        TXS_OFFER = 2'd1,
        TXS_HOLD  = 2'd2
    } tx_state_t;

    typedef struct packed {
        logic status;
        logic txfree;
        logic rxready;
        logic data;
        logic window;
    } reg_hit_t;

endpackage

// File: rtl/uart_host_decode.sv
module uart_host_decode
    import uart_fifo_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit
);
    always_comb begin
        hit         = '0;
        hit.status  = (addr == OFS_STATUS);
        hit.txfree  = (addr == OFS_TXFREE);
        hit.rxready = (addr == OFS_RXREADY);
        hit.data    = (addr == OFS_DATA);
        hit.window  = (addr[ADDR_W-1:ADDR_W-3] == WIN_TOP);
    end
endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int unsigned DEPTH_LOG2 = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            push_n,
    input  logic [7:0]            push_d0,
    input  logic [7:0]            push_d1,
    input  logic [1:0]            pop_n,
    output logic [7:0]            head0,
    output logic [7:0]            head1,
    output logic [DEPTH_LOG2:0]   cnt,
    output logic [DEPTH_LOG2:0]   cnt_nxt
);
    localparam int unsigned DEPTH = 1 << DEPTH_LOG2;
    localparam int unsigned PW    = DEPTH_LOG2;
    localparam int unsigned CW    = DEPTH_LOG2 + 1;

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr1;
    logic [PW-1:0] rd_ptr1;

    assign wr_ptr1 = wr_ptr + 1'b1;
    assign rd_ptr1 = rd_ptr + 1'b1;
    assign head0   = mem[rd_ptr];
    assign head1   = mem[rd_ptr1];
    assign cnt_nxt = cnt + CW'(push_n) - CW'(pop_n);

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wr_ptr]  <= push_d0;
        if (push_n == 2'd2) mem[wr_ptr1] <= push_d1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(push_n);
            rd_ptr <= rd_ptr + PW'(pop_n);
            cnt    <= cnt_nxt;
        end
    end

    // R7: the writer never offers more bytes than there are free slots
    p_push_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(push_n) <= (CW'(DEPTH) - cnt));

    // R5: the reader never removes more bytes than are held
    p_pop_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= cnt);

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/uart_tx_pacer.sv
module uart_tx_pacer
    import uart_fifo_pkg::*;
#(
    parameter int unsigned CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_nxt,
    input  logic          fc_en,
    input  logic          peer_cts,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic          pop
);
    tx_state_t state;
    tx_state_t state_nxt;
    logic      has_nxt;
    logic      blocked;

    assign has_nxt = (cnt_nxt != '0);
    assign blocked = fc_en && !peer_cts;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TXS_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            TXS_IDLE: begin
                if (has_nxt) state_nxt = blocked ? TXS_HOLD : TXS_OFFER;
            end
            TXS_OFFER: begin
                if (!has_nxt)    state_nxt = TXS_IDLE;
                else if (blocked) state_nxt = TXS_HOLD;
            end
            TXS_HOLD: begin
                if (!has_nxt)     state_nxt = TXS_IDLE;
                else if (!blocked) state_nxt = TXS_OFFER;
            end
            default: state_nxt = TXS_IDLE;
        endcase
    end

    always_comb begin
        tx_valid = (state == TXS_OFFER);
        pop      = tx_valid && tx_ready;
    end

    // R10: a blocked peer removes the offer by the next cycle
    p_hold_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> !tx_valid);

    // R9: an offer not taken stays up while the peer allows it
    p_offer_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !blocked) |=> tx_valid);
endmodule

// File: rtl/uart_fifo_port.sv
module uart_fifo_port
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fc_en,
    input  logic              peer_cts,
    input  logic              tx_busy,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data
);
    localparam int unsigned DEPTH = 1 << DEPTH_LOG2;
    localparam int unsigned CW    = DEPTH_LOG2 + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    reg_hit_t hit;
    logic     wr_op;
    logic     rd_op;
    logic     clr_ovf;

    logic [1:0]    tx_want, tx_grant, tx_pop_n;
    logic [7:0]    tx_d0;
    logic [CW-1:0] tx_cnt, tx_cnt_nxt, tx_free;
    logic          tx_pop;
    logic [7:0]    unused_tx_head1;

    logic [1:0]    rx_want, rx_grant, rx_push_n;
    logic [7:0]    rx_h0, rx_h1, rx_b0, rx_b1;
    logic [CW-1:0] rx_cnt, unused_rx_cnt_nxt;
    logic          rx_full, ovf_set, ovf_q;
    logic          unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:16], bus_wdata[14:12], bus_wdata[10:8]};

    uart_host_decode u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    assign wr_op   = bus_sel && bus_wr;
    assign rd_op   = bus_sel && !bus_wr;
    assign clr_ovf = wr_op && hit.status && bus_wdata[ST_RX_OVF];

    // transmit side: host pushes, pacer pops
    always_comb begin
        tx_want = 2'd0;
        if (wr_op && hit.data)   tx_want = 2'd1;
        if (wr_op && hit.window) tx_want = bus_wide ? 2'd2 : 2'd1;
        tx_free = FULL_CNT - tx_cnt;
        if (tx_free >= CW'(tx_want)) tx_grant = tx_want;
        else if (tx_free != '0)      tx_grant = 2'd1;
        else                         tx_grant = 2'd0;
        tx_d0    = (hit.window && bus_wide) ? bus_wdata[15:8] : bus_wdata[7:0];
        tx_pop_n = {1'b0, tx_pop};
    end

    uart_byte_fifo #(.DEPTH_LOG2(DEPTH_LOG2)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_n  (tx_grant),
        .push_d0 (tx_d0),
        .push_d1 (bus_wdata[7:0]),
        .pop_n   (tx_pop_n),
        .head0   (tx_data),
        .head1   (unused_tx_head1),
        .cnt     (tx_cnt),
        .cnt_nxt (tx_cnt_nxt)
    );

    uart_tx_pacer #(.CW(CW)) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_nxt  (tx_cnt_nxt),
        .fc_en    (fc_en),
        .peer_cts (peer_cts),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .pop      (tx_pop)
    );

    // receive side: line pushes, host pops
    always_comb begin
        rx_full   = (rx_cnt == FULL_CNT);
        rx_push_n = (rx_valid && !rx_full) ? 2'd1 : 2'd0;
        ovf_set   = rx_valid && rx_full;
        rx_want   = 2'd0;
        if (rd_op && hit.data)   rx_want = 2'd1;
        if (rd_op && hit.window) rx_want = bus_wide ? 2'd2 : 2'd1;
        if (rx_cnt >= CW'(rx_want)) rx_grant = rx_want;
        else if (rx_cnt != '0)      rx_grant = 2'd1;
        else                        rx_grant = 2'd0;
        rx_b0 = (rx_cnt != '0)         ? rx_h0 : 8'h00;
        rx_b1 = (rx_cnt >= CW'(2'd2))  ? rx_h1 : 8'h00;
    end

    uart_byte_fifo #(.DEPTH_LOG2(DEPTH_LOG2)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_n  (rx_push_n),
        .push_d0 (rx_data),
        .push_d1 (8'h00),
        .pop_n   (rx_grant),
        .head0   (rx_h0),
        .head1   (rx_h1),
        .cnt     (rx_cnt),
        .cnt_nxt (unused_rx_cnt_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (ovf_set) ovf_q <= 1'b1;
        else if (clr_ovf) ovf_q <= 1'b0;
    end

    // read mux
    always_comb begin
        bus_rdata = 32'h0;
        if (rd_op) begin
            if (hit.status) begin
                bus_rdata[ST_TX_NF]  = (tx_cnt != FULL_CNT);
                bus_rdata[ST_TX_F]   = (tx_cnt == FULL_CNT);
                bus_rdata[ST_TX_HF]  = (tx_cnt >= HALF_CNT);
                bus_rdata[ST_TX_ACT] = tx_busy || (tx_cnt != '0);
                bus_rdata[ST_RX_NE]  = (rx_cnt != '0);
                bus_rdata[ST_RX_F]   = rx_full;
                bus_rdata[ST_RX_HF]  = (rx_cnt >= HALF_CNT);
                bus_rdata[ST_RX_OVF] = ovf_q;
            end
            if (hit.txfree)  bus_rdata = 32'(tx_free);
            if (hit.rxready) bus_rdata = 32'(rx_cnt);
            if (hit.data)    bus_rdata = {24'h0, rx_b0};
            if (hit.window)  bus_rdata = bus_wide ? {16'h0, rx_b0, rx_b1}
                                                  : {24'h0, rx_b0};
        end
    end

    // R8: a lost byte is always recorded
    p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_cnt == FULL_CNT) |=> ovf_q);

    // R8: only a host clear removes the flag
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_ovf) |=> ovf_q);

    // R9: an offered byte always has a queue entry behind it
    p_valid_has_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_cnt != '0));

    // R5: an empty receive queue is not drained
    p_rx_empty_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0 && !rx_valid) |=> (rx_cnt == '0));
endmodule

// File: tb/tb_uart_fifo_port.sv
module tb_uart_fifo_port;
    localparam int unsigned DL = 3;
    localparam int unsigned D  = 1 << DL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fc_en = 1'b0, peer_cts = 1'b0, tx_busy = 1'b0;
    logic        tx_valid, tx_ready = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    uart_fifo_port #(.DEPTH_LOG2(DL)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fc_en(fc_en), .peer_cts(peer_cts),
        .tx_busy(tx_busy), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [12:0] a, input logic [31:0] d, input logic w);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = w;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic bus_read(input logic [12:0] a, input logic w, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wide = w;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic rx_put(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic take_tx(input string req, input logic [7:0] exp);
        @(negedge clk);
        #1;
        check(req, {31'h0, tx_valid}, 32'h1);
        check(req, {24'h0, tx_data}, {24'h0, exp});
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
        bus_read(13'h014, 1'b0, d); check("R1 status", d, 32'h001);
        bus_read(13'h018, 1'b0, d); check("R1 free", d, D);
        bus_read(13'h01C, 1'b0, d); check("R1 ready", d, 32'h0);
    endtask

    task automatic t_tx_basic();
        logic [31:0] d;
        bus_write(13'h020, 32'hFFFF_FFA5, 1'b0);
        #1 check("R9 valid after write", {31'h0, tx_valid}, 32'h1);
        check("R9 head", {24'h0, tx_data}, 32'hA5);
        bus_read(13'h014, 1'b0, d); check("R2 R11 status one byte", d, 32'h009);
        bus_write(13'h1000, 32'h0000_9977, 1'b0);
        bus_write(13'h13FE, 32'h0000_1234, 1'b1);
        bus_read(13'h018, 1'b0, d); check("R3 free after 4", d, D - 4);
        bus_read(13'h014, 1'b0, d); check("R12 tx half at D/2", d, 32'h00D);
        take_tx("R9 order 0", 8'hA5);
        take_tx("R6 narrow window", 8'h77);
        bus_read(13'h014, 1'b0, d); check("R12 tx below half", d, 32'h009);
        take_tx("R6 wide high first", 8'h12);
        take_tx("R6 wide low second", 8'h34);
        @(negedge clk); #1 check("R9 drained", {31'h0, tx_valid}, 32'h0);
        bus_read(13'h014, 1'b0, d); check("R11 idle", d, 32'h001);
    endtask

    task automatic t_tx_full();
        logic [31:0] d;
        for (int i = 0; i < D - 1; i++) bus_write(13'h020, 32'(8'h40 + i), 1'b0);
        bus_write(13'h1000, 32'h0000_C3D4, 1'b1);
        bus_read(13'h018, 1'b0, d); check("R7 one free high only", d, 32'h0);
        bus_read(13'h014, 1'b0, d); check("R2 tx full flags", d, 32'h00E);
        bus_write(13'h020, 32'h0000_00EE, 1'b0);
        bus_read(13'h018, 1'b0, d); check("R7 full write ignored", d, 32'h0);
        for (int i = 0; i < D - 1; i++) take_tx("R9 full order", 8'(8'h40 + i));
        take_tx("R7 last is high byte", 8'hC3);
        bus_read(13'h018, 1'b0, d); check("R7 empty after drain", d, D);
    endtask

    task automatic t_flow();
        logic [31:0] d;
        @(negedge clk); fc_en = 1'b1; peer_cts = 1'b0;
        bus_write(13'h020, 32'h0000_005A, 1'b0);
        @(negedge clk); #1 check("R10 held", {31'h0, tx_valid}, 32'h0);
        bus_read(13'h014, 1'b0, d); check("R11 active while held", d, 32'h009);
        @(negedge clk); peer_cts = 1'b1;
        @(negedge clk); #1 check("R10 released", {31'h0, tx_valid}, 32'h1);
        @(negedge clk); fc_en = 1'b0; peer_cts = 1'b0;
        @(negedge clk); #1 check("R10 ignored when disabled", {31'h0, tx_valid}, 32'h1);
        @(negedge clk); fc_en = 1'b1;
        @(negedge clk); #1 check("R10 blocks offer", {31'h0, tx_valid}, 32'h0);
        @(negedge clk); fc_en = 1'b0;
        take_tx("R10 byte after release", 8'h5A);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        @(negedge clk); tx_busy = 1'b1;
        bus_read(13'h014, 1'b0, d); check("R11 busy empty", d, 32'h009);
        @(negedge clk); tx_busy = 1'b0;
        bus_read(13'h014, 1'b0, d); check("R11 not busy", d, 32'h001);
    endtask

    task automatic t_rx();
        logic [31:0] d;
        bus_read(13'h020, 1'b0, d); check("R5 empty read zero", d, 32'h0);
        bus_read(13'h01C, 1'b0, d); check("R5 empty read no change", d, 32'h0);
        rx_put(8'h11); rx_put(8'h22); rx_put(8'h33);
        bus_read(13'h01C, 1'b0, d); check("R4 ready three", d, 32'h3);
        bus_read(13'h014, 1'b0, d); check("R2 rx not empty", d, 32'h101);
        bus_read(13'h020, 1'b0, d); check("R5 data read", d, 32'h11);
        bus_read(13'h1200, 1'b1, d); check("R6 wide read", d, 32'h2233);
        bus_read(13'h01C, 1'b0, d); check("R6 wide pops two", d, 32'h0);
        rx_put(8'h44);
        bus_read(13'h1004, 1'b1, d); check("R6 wide partial", d, 32'h4400);
        bus_read(13'h01C, 1'b0, d); check("R6 partial pops one", d, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        for (int i = 0; i < D; i++) rx_put(8'(8'h80 + i));
        bus_read(13'h014, 1'b0, d); check("R12 rx full no ovf", d, 32'h701);
        rx_put(8'hF0);
        bus_read(13'h014, 1'b0, d); check("R8 overflow set", d, 32'hF01);
        bus_write(13'h014, 32'h0000_07FF, 1'b0);
        bus_read(13'h014, 1'b0, d); check("R8 zero write keeps", d, 32'hF01);
        bus_write(13'h014, 32'h0000_0800, 1'b0);
        bus_read(13'h014, 1'b0, d); check("R8 cleared", d, 32'h701);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'hF1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 13'h014; bus_wdata = 32'h800;
        @(negedge clk);
        rx_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(13'h014, 1'b0, d); check("R8 set beats clear", d, 32'hF01);
        for (int i = 0; i < D; i++) begin
            bus_read(13'h020, 1'b0, d);
            check("R8 kept bytes in order", d, 32'(8'h80 + i));
        end
        bus_read(13'h01C, 1'b0, d); check("R8 dropped bytes absent", d, 32'h0);
        bus_write(13'h014, 32'h0000_0800, 1'b0);
        bus_read(13'h014, 1'b0, d); check("R8 final clear", d, 32'h001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_basic();
        t_tx_full();
        t_flow();
        t_busy();
        t_rx();
        t_overflow();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule